// File: doc/BRIEF.md
# Signature Command Phase Sequencer

This block is the control core of a signature accelerator. It takes one high-level command at a time: cold sign, cached-key sign, verify or clear key. It walks through the phases that command needs. In each phase it starts exactly one child engine with a start/done handshake. The engines are hash, scalar (clamp, reduce, canonical check, multiply-add), fixed-base multiply, variable-base multiply, point codec (encode/decode) and point compare. A sign command carries only a seed and a message length. The derived scalar, prefix, nonce, R and challenge never come from the host. Message bytes reach the hash engine through a separate stream feeder, which lies outside this block.

The block keeps a retained expanded-key set (scalar a, prefix, public point A). A cold sign fills this set, and a later cached-key sign reuses it. Clear key invalidates the set and zeroes it. The next-phase decision is a purely combinational kernel. It is kept apart from the phase, command, key and result registers. Verification stops at its first failing check. The result leaves on a valid/ready port as a 3-bit code, together with the captured R and S words of a signature.

States: IDLE, SEED_HASH, CLAMP, A_MUL, A_ENC, R_HASH, R_RED, R_MUL, R_ENC, K_HASH, K_RED, S_COMB, S_CHECK, A_DEC, R_DEC, SB_MUL, KA_MUL, EQ_CMP, REPORT.

Transitions:
- IDLE goes to SEED_HASH on cold sign, to S_CHECK on verify, and to R_HASH on cached sign when the key is valid.
- Cached sign without a valid key, and clear, go from IDLE straight to REPORT.
- Cold sign runs SEED_HASH→CLAMP→A_MUL→A_ENC→R_HASH.
- Both sign commands then run R_HASH→R_RED→R_MUL→R_ENC→K_HASH→K_RED→S_COMB→REPORT.
- Verify runs S_CHECK→A_DEC→R_DEC→K_HASH→K_RED→SB_MUL→KA_MUL→EQ_CMP→REPORT.
- Any failing check goes to REPORT.
- REPORT goes to IDLE when the result is taken.

Top module: `sigseq_top`

## Requirements
- R1: After reset cmd_ready is 1, res_valid is 0, eng_start is 0, key_valid is 0 and work_a, work_prefix and work_pub are 0.
- R2: Cold sign (cmd_op 0) starts engines in the order hash, scalar, fixed-mul, codec, hash, scalar, fixed-mul, codec, hash, scalar, scalar. Engine index is the eng_start bit: hash 0, scalar 1, fixed-mul 2, variable-mul 3, codec 4, compare 5. It ends with code 0 (success). res_r holds the data of the second codec step and res_s the data of the last step.
- R3: A successful cold sign retains the first hash data as prefix, the first scalar data as a and the first codec data as A, and sets key_valid.
- R4: Cached sign (cmd_op 1) with a valid key loads the retained set onto work_* and starts hash, scalar, fixed-mul, codec, hash, scalar, scalar, ending with code 0.
- R5: Cached sign while key_valid is 0 reports code 5 (missing key) and starts no engine.
- R6: Clear (cmd_op 3) starts no engine, reports code 0, clears key_valid and drives work_a, work_prefix and work_pub to 0.
- R7: Verify (cmd_op 2) starts scalar, codec, codec, hash, scalar, fixed-mul, variable-mul, compare, and reports 0 when no check fails.
- R8: Verify stops at the first failing check. Flag bit 1 on the scalar check gives code 1 (non-canonical S). On a decode step, flag bit 2 gives code 2 (malformed) and takes priority over flag bit 3, which gives code 3 (small order).
- R9: Flag bit 4 on the compare step gives code 6 (equation mismatch).
- R10: Flag bit 0 on a hash step aborts with code 4 (framing) and leaves the retained key set unchanged. Flag bit 0 on a non-hash step has no effect.
- R11: cmd_ready is 0 from command acceptance until the result handshake completes. res_code is held stable while res_valid is high and res_ready is low.
- R12: Each phase raises its engine's start bit for exactly one cycle, and at most one start bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted |
| cmd_op | input | 2 | 0 cold sign, 1 cached sign, 2 verify, 3 clear |
| cmd_seed | input | W | Seed word for signing |
| cmd_len | input | LEN_W | Message length in bytes |
| job_seed | output | W | Latched seed for the engines |
| job_len | output | LEN_W | Latched message length for the feeder |
| eng_start | output | 6 | One-hot engine start pulse |
| eng_phase | output | 5 | Current phase, tells the engine which operation to run |
| eng_done | input | 1 | Engine finished |
| eng_flags | input | 5 | Status with done: framing, non-canonical, malformed, small order, mismatch |
| eng_data | input | W | Result word with done |
| work_a | output | W | Scalar a for the current job |
| work_prefix | output | W | Prefix for the current job |
| work_pub | output | W | Public point A for the current job |
| key_valid | output | 1 | Retained key set is valid |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_code | output | 3 | Result code |
| res_r | output | W | Captured R word |
| res_s | output | W | Captured S word |

## Verification
The bench builds the block with W = 32 and LEN_W = 16. The 32-bit words keep the scripted engine data readable, so every captured and retained word can be traced to the step that produced it. Engine latency is varied from one to three cycles. That brings within reach the single-cycle start pulse, done arriving on the first cycle after start, and the key-set staging across framing aborts followed by cached signing.

// File: rtl/sigseq_pkg.sv
package sigseq_pkg;

    localparam int NUM_ENG = 6;
    localparam int FLAG_W  = 5;

    localparam int EN_HASH   = 0;
    localparam int EN_SCALAR = 1;
    localparam int EN_FIXMUL = 2;
    localparam int EN_VARMUL = 3;
    localparam int EN_CODEC  = 4;
    localparam int EN_CMP    = 5;

    localparam int FL_FRAMING   = 0;
    localparam int FL_NONCANON  = 1;
    localparam int FL_MALFORMED = 2;
    localparam int FL_SMALL     = 3;
    localparam int FL_MISMATCH  = 4;

    typedef enum logic [1:0] {
        OP_COLD   = 2'd0,
        OP_CACHED = 2'd1,
        OP_VERIFY = 2'd2,
        OP_CLEAR  = 2'd3
    } op_t;

    typedef enum logic [2:0] {
        RC_OK        = 3'd0,
        RC_NONCANON  = 3'd1,
        RC_MALFORMED = 3'd2,
        RC_SMALL     = 3'd3,
        RC_FRAMING   = 3'd4,
        RC_NOKEY     = 3'd5,
        RC_MISMATCH  = 3'd6
    } rc_t;

    typedef enum logic [4:0] {
        PH_IDLE, PH_SEED_HASH, PH_CLAMP, PH_A_MUL, PH_A_ENC,
        PH_R_HASH, PH_R_RED, PH_R_MUL, PH_R_ENC,
        PH_K_HASH, PH_K_RED, PH_S_COMB,
        PH_S_CHECK, PH_A_DEC, PH_R_DEC, PH_SB_MUL, PH_KA_MUL, PH_EQ_CMP,
        PH_REPORT
    } phase_t;

    function automatic logic [NUM_ENG-1:0] eng_bit(int idx);
        logic [NUM_ENG-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic [NUM_ENG-1:0] phase_engine(phase_t p);
        logic [NUM_ENG-1:0] e;
        unique case (p)
            PH_SEED_HASH, PH_R_HASH, PH_K_HASH:            e = eng_bit(EN_HASH);
            PH_CLAMP, PH_R_RED, PH_K_RED, PH_S_COMB,
            PH_S_CHECK:                                    e = eng_bit(EN_SCALAR);
            PH_A_MUL, PH_R_MUL, PH_SB_MUL:                 e = eng_bit(EN_FIXMUL);
            PH_KA_MUL:                                     e = eng_bit(EN_VARMUL);
            PH_A_ENC, PH_R_ENC, PH_A_DEC, PH_R_DEC:        e = eng_bit(EN_CODEC);
            PH_EQ_CMP:                                     e = eng_bit(EN_CMP);
            default:                                       e = '0;
        endcase
        return e;
    endfunction

    function automatic logic is_hash_phase(phase_t p);
        return (p == PH_SEED_HASH) || (p == PH_R_HASH) || (p == PH_K_HASH);
    endfunction

endpackage

// File: rtl/sigseq_next.sv
module sigseq_next
    import sigseq_pkg::*;
(
    input  phase_t              phase,
    input  op_t                 new_op,
    input  op_t                 cur_op,
    input  logic                cmd_fire,
    input  logic                step_done,
    input  logic [FLAG_W-1:0]   flags,
    input  logic                key_valid,
    input  logic                res_take,
    output phase_t              nxt_phase,
    output logic                load_code,
    output rc_t                 nxt_code,
    output logic                commit,
    output logic                clear,
    output logic                stage_load
);

    always_comb begin
        nxt_phase  = phase;
        load_code  = 1'b0;
        nxt_code   = RC_OK;
        commit     = 1'b0;
        clear      = 1'b0;
        stage_load = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (cmd_fire) begin
                    unique case (new_op)
                        OP_COLD:   nxt_phase = PH_SEED_HASH;
                        OP_VERIFY: nxt_phase = PH_S_CHECK;
                        OP_CACHED: begin
                            if (key_valid) begin
                                nxt_phase  = PH_R_HASH;
                                stage_load = 1'b1;
                            end else begin
                                nxt_phase = PH_REPORT;
                                load_code = 1'b1;
                                nxt_code  = RC_NOKEY;
                            end
                        end
                        OP_CLEAR: begin
                            nxt_phase = PH_REPORT;
                            load_code = 1'b1;
                            nxt_code  = RC_OK;
                            clear     = 1'b1;
                        end
                        default: nxt_phase = PH_IDLE;
                    endcase
                end
            end
            PH_REPORT: begin
                if (res_take) nxt_phase = PH_IDLE;
            end
            default: begin
                if (step_done) begin
                    if (is_hash_phase(phase) && flags[FL_FRAMING]) begin
                        nxt_phase = PH_REPORT;
                        load_code = 1'b1;
                        nxt_code  = RC_FRAMING;
                    end else begin
                        unique case (phase)
                            PH_SEED_HASH: nxt_phase = PH_CLAMP;
                            PH_CLAMP:     nxt_phase = PH_A_MUL;
                            PH_A_MUL:     nxt_phase = PH_A_ENC;
                            PH_A_ENC:     nxt_phase = PH_R_HASH;
                            PH_R_HASH:    nxt_phase = PH_R_RED;
                            PH_R_RED:     nxt_phase = PH_R_MUL;
                            PH_R_MUL:     nxt_phase = PH_R_ENC;
                            PH_R_ENC:     nxt_phase = PH_K_HASH;
                            PH_K_HASH:    nxt_phase = PH_K_RED;
                            PH_K_RED:     nxt_phase = (cur_op == OP_VERIFY) ? PH_SB_MUL : PH_S_COMB;
                            PH_S_COMB: begin
                                nxt_phase = PH_REPORT;
                                load_code = 1'b1;
                                nxt_code  = RC_OK;
                                commit    = (cur_op == OP_COLD);
                            end
                            PH_S_CHECK: begin
                                if (flags[FL_NONCANON]) begin
                                    nxt_phase = PH_REPORT;
                                    load_code = 1'b1;
                                    nxt_code  = RC_NONCANON;
                                end else begin
                                    nxt_phase = PH_A_DEC;
                                end
                            end
                            PH_A_DEC, PH_R_DEC: begin
                                if (flags[FL_MALFORMED]) begin
                                    nxt_phase = PH_REPORT;
                                    load_code = 1'b1;
                                    nxt_code  = RC_MALFORMED;
                                end else if (flags[FL_SMALL]) begin
                                    nxt_phase = PH_REPORT;
                                    load_code = 1'b1;
                                    nxt_code  = RC_SMALL;
                                end else begin
                                    nxt_phase = (phase == PH_A_DEC) ? PH_R_DEC : PH_K_HASH;
                                end
                            end
                            PH_SB_MUL:    nxt_phase = PH_KA_MUL;
                            PH_KA_MUL:    nxt_phase = PH_EQ_CMP;
                            PH_EQ_CMP: begin
                                nxt_phase = PH_REPORT;
                                load_code = 1'b1;
                                nxt_code  = flags[FL_MISMATCH] ? RC_MISMATCH : RC_OK;
                            end
                            default:      nxt_phase = PH_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/sigseq_launch.sv
module sigseq_launch
    import sigseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  phase_t              phase,
    input  logic                eng_done,
    output logic [NUM_ENG-1:0]  eng_start,
    output logic                step_done
);

    logic launched;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launched <= 1'b0;
        end else if (step_done) begin
            launched <= 1'b0;
        end else if (|eng_start) begin
            launched <= 1'b1;
        end
    end

    always_comb begin
        eng_start = phase_engine(phase) & {NUM_ENG{~launched}};
        step_done = launched & eng_done;
    end

    assert_start_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_start));

    assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|eng_start) |=> !(|eng_start));

endmodule

// File: rtl/sigseq_keycache.sv
module sigseq_keycache
    import sigseq_pkg::*;
#(
    parameter int W = 256
)(
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic          step_done,
    input  logic [W-1:0]  eng_data,
    input  logic          commit,
    input  logic          clear,
    input  logic          stage_load,
    output logic [W-1:0]  work_a,
    output logic [W-1:0]  work_prefix,
    output logic [W-1:0]  work_pub,
    output logic          key_valid
);

    logic [W-1:0] kc_a, kc_prefix, kc_pub;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            kc_a        <= '0;
            kc_prefix   <= '0;
            kc_pub      <= '0;
            work_a      <= '0;
            work_prefix <= '0;
            work_pub    <= '0;
            key_valid   <= 1'b0;
        end else begin
            if (stage_load) begin
                work_a      <= kc_a;
                work_prefix <= kc_prefix;
                work_pub    <= kc_pub;
            end
            if (step_done && phase == PH_SEED_HASH) work_prefix <= eng_data;
            if (step_done && phase == PH_CLAMP)     work_a      <= eng_data;
            if (step_done && phase == PH_A_ENC)     work_pub    <= eng_data;
            if (commit) begin
                kc_a      <= work_a;
                kc_prefix <= work_prefix;
                kc_pub    <= work_pub;
                key_valid <= 1'b1;
            end
        end
    end

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!key_valid && work_a == '0 && work_prefix == '0 && work_pub == '0));

    assert_commit_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> key_valid);

endmodule

// File: rtl/sigseq_top.sv
module sigseq_top
    import sigseq_pkg::*;
#(
    parameter int W     = 256,
    parameter int LEN_W = 32
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [W-1:0]        cmd_seed,
    input  logic [LEN_W-1:0]    cmd_len,
    output logic [W-1:0]        job_seed,
    output logic [LEN_W-1:0]    job_len,
    output logic [5:0]          eng_start,
    output logic [4:0]          eng_phase,
    input  logic                eng_done,
    input  logic [4:0]          eng_flags,
    input  logic [W-1:0]        eng_data,
    output logic [W-1:0]        work_a,
    output logic [W-1:0]        work_prefix,
    output logic [W-1:0]        work_pub,
    output logic                key_valid,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [2:0]          res_code,
    output logic [W-1:0]        res_r,
    output logic [W-1:0]        res_s
);

    phase_t phase_q, nxt_phase;
    op_t    op_q, new_op;
    rc_t    code_q, nxt_code;
    logic   cmd_fire, res_take, step_done;
    logic   load_code, commit, clear, stage_load;
    logic [NUM_ENG-1:0] start_vec;

    assign new_op   = op_t'(cmd_op);
    assign cmd_fire = cmd_valid && cmd_ready;
    assign res_take = res_valid && res_ready;

    sigseq_next u_next (
        .phase      (phase_q),
        .new_op     (new_op),
        .cur_op     (op_q),
        .cmd_fire   (cmd_fire),
        .step_done  (step_done),
        .flags      (eng_flags),
        .key_valid  (key_valid),
        .res_take   (res_take),
        .nxt_phase  (nxt_phase),
        .load_code  (load_code),
        .nxt_code   (nxt_code),
        .commit     (commit),
        .clear      (clear),
        .stage_load (stage_load)
    );

    sigseq_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase_q),
        .eng_done  (eng_done),
        .eng_start (start_vec),
        .step_done (step_done)
    );

    sigseq_keycache #(.W(W)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase_q),
        .step_done   (step_done),
        .eng_data    (eng_data),
        .commit      (commit),
        .clear       (clear),
        .stage_load  (stage_load),
        .work_a      (work_a),
        .work_prefix (work_prefix),
        .work_pub    (work_pub),
        .key_valid   (key_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            op_q     <= OP_COLD;
            code_q   <= RC_OK;
            job_seed <= '0;
            job_len  <= '0;
            res_r    <= '0;
            res_s    <= '0;
        end else begin
            phase_q <= nxt_phase;
            if (cmd_fire) begin
                op_q     <= new_op;
                job_seed <= cmd_seed;
                job_len  <= cmd_len;
            end
            if (load_code) code_q <= nxt_code;
            if (step_done && phase_q == PH_R_ENC)  res_r <= eng_data;
            if (step_done && phase_q == PH_S_COMB) res_s <= eng_data;
        end
    end

    always_comb begin
        cmd_ready = (phase_q == PH_IDLE);
        res_valid = (phase_q == PH_REPORT);
        res_code  = code_q;
        eng_start = start_vec;
        eng_phase = phase_q;
    end

    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cmd_ready);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_code)));

    assert_missing_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == 2'd1 && !key_valid) |=> (res_valid && res_code == 3'd5 && eng_start == '0));

endmodule

// File: tb/sim_sigseq_top.sv
module sim_sigseq_top;

    localparam int W = 32;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [W-1:0] cmd_seed = '0;
    logic [LW-1:0] cmd_len = '0;
    logic res_ready = 1'b0;
    logic eng_done = 1'b0;
    logic [4:0] eng_flags = '0;
    logic [W-1:0] eng_data = '0;

    logic cmd_ready, key_valid, res_valid;
    logic [W-1:0] job_seed, work_a, work_prefix, work_pub, res_r, res_s;
    logic [LW-1:0] job_len;
    logic [5:0] eng_start;
    logic [4:0] eng_phase;
    logic [2:0] res_code;

    always #2 clk = ~clk;

    sigseq_top #(.W(W), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_seed(cmd_seed), .cmd_len(cmd_len),
        .job_seed(job_seed), .job_len(job_len), .eng_start(eng_start),
        .eng_phase(eng_phase), .eng_done(eng_done), .eng_flags(eng_flags),
        .eng_data(eng_data), .work_a(work_a), .work_prefix(work_prefix),
        .work_pub(work_pub), .key_valid(key_valid), .res_valid(res_valid),
        .res_ready(res_ready), .res_code(res_code), .res_r(res_r), .res_s(res_s)
    );

    int n_chk = 0;
    int n_fail = 0;
    int lat = 1;
    bit model_busy = 1'b0;
    string cur_req = "R2";

    int q_eng[$];
    logic [4:0] q_flg[$];
    logic [W-1:0] q_dat[$];

    int cold_seq[11] = '{0, 1, 2, 4, 0, 1, 2, 4, 0, 1, 1};
    int cach_seq[7]  = '{0, 1, 2, 4, 0, 1, 1};
    int ver_seq[8]   = '{1, 4, 4, 0, 1, 2, 3, 5};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // engine responder: checks each start against the scripted order
    int pend = 0;
    logic [4:0] p_flg;
    logic [W-1:0] p_dat;
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (eng_start != 6'd0) begin
            if (q_eng.size() == 0) begin
                chk(1'b0, {cur_req, " R12 unexpected start"}, 64'(eng_start), 64'd0);
            end else begin
                chk(eng_start == (6'd1 << q_eng[0]), {cur_req, " R12 engine order"},
                    64'(eng_start), 64'(6'd1 << q_eng[0]));
                void'(q_eng.pop_front());
                p_flg = q_flg.pop_front();
                p_dat = q_dat.pop_front();
                pend = lat;
            end
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                eng_done  = 1'b1;
                eng_flags = p_flg;
                eng_data  = p_dat;
            end
        end
    end

    // per-clock comparison of the busy model against cmd_ready (R11)
    always @(posedge clk) begin
        #1;
        if (rst_n) chk(cmd_ready === !model_busy, "R11 cmd_ready vs busy model",
                       64'(cmd_ready), 64'(!model_busy));
    end

    task automatic load(input int kind, input int n, input logic [W-1:0] base,
                        input int fidx, input logic [4:0] fflg);
        for (int i = 0; i < n; i++) begin
            int e;
            e = (kind == 0) ? cold_seq[i] : (kind == 1) ? cach_seq[i] : ver_seq[i];
            q_eng.push_back(e);
            q_flg.push_back((i == fidx) ? fflg : 5'd0);
            q_dat.push_back(base + W'(i));
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [2:0] exp_code, input string req);
        cur_req = req;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_seed = 32'h5EED0000 + W'(op); cmd_len = 16'd64;
        @(posedge clk);
        model_busy = 1'b1;
        #1 cmd_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        chk(res_code == exp_code, {req, " result code"}, 64'(res_code), 64'(exp_code));
        @(negedge clk);
        chk(res_valid && res_code == exp_code, "R11 result held", 64'(res_code), 64'(exp_code));
        res_ready = 1'b1;
        @(posedge clk);
        model_busy = 1'b0;
        #1 res_ready = 1'b0;
        chk(q_eng.size() == 0, {req, " all scripted steps run"}, 64'(q_eng.size()), 64'd0);
        q_eng.delete(); q_flg.delete(); q_dat.delete();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
        chk(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 64'd0);
        chk(eng_start == 6'd0, "R1 eng_start", 64'(eng_start), 64'd0);
        chk(key_valid == 1'b0, "R1 key_valid", 64'(key_valid), 64'd0);
        chk({work_a, work_prefix, work_pub} == '0, "R1 work words", 64'(work_a), 64'd0);

        // R2 / R3 cold sign
        lat = 1;
        load(0, 11, 32'hA000, -1, 5'd0);
        run_cmd(2'd0, 3'd0, "R2");
        chk(res_r == 32'hA007, "R2 res_r", 64'(res_r), 64'hA007);
        chk(res_s == 32'hA00A, "R2 res_s", 64'(res_s), 64'hA00A);
        chk(key_valid == 1'b1, "R3 key_valid", 64'(key_valid), 64'd1);
        chk(work_prefix == 32'hA000, "R3 prefix", 64'(work_prefix), 64'hA000);
        chk(work_a == 32'hA001, "R3 a", 64'(work_a), 64'hA001);
        chk(work_pub == 32'hA003, "R3 A", 64'(work_pub), 64'hA003);

        // R4 cached sign
        lat = 2;
        load(1, 7, 32'hB000, -1, 5'd0);
        run_cmd(2'd1, 3'd0, "R4");
        chk(res_r == 32'hB003, "R4 res_r", 64'(res_r), 64'hB003);
        chk(res_s == 32'hB006, "R4 res_s", 64'(res_s), 64'hB006);
        chk(work_a == 32'hA001, "R4 reuses a", 64'(work_a), 64'hA001);

        // R10 framing in R hash of a cold sign: abort, cache unchanged
        lat = 1;
        load(0, 5, 32'hC000, 4, 5'b00001);
        run_cmd(2'd0, 3'd4, "R10");
        load(1, 7, 32'hC100, -1, 5'd0);
        run_cmd(2'd1, 3'd0, "R10 follow-up");
        chk(work_prefix == 32'hA000, "R10 prefix kept", 64'(work_prefix), 64'hA000);
        chk(work_a == 32'hA001, "R10 a kept", 64'(work_a), 64'hA001);
        chk(work_pub == 32'hA003, "R10 A kept", 64'(work_pub), 64'hA003);

        // R10 framing flag on a non-hash step has no effect
        lat = 3;
        load(0, 11, 32'hD000, 1, 5'b00001);
        run_cmd(2'd0, 3'd0, "R10 ignored flag");
        chk(work_a == 32'hD001, "R10 non-hash flag ignored", 64'(work_a), 64'hD001);

        // R7 verify pass
        lat = 1;
        load(2, 8, 32'hE000, -1, 5'd0);
        run_cmd(2'd2, 3'd0, "R7");

        // R8 first-failing check
        load(2, 1, 32'hE100, 0, 5'b00010);
        run_cmd(2'd2, 3'd1, "R8 noncanonical");
        load(2, 2, 32'hE200, 1, 5'b01100);
        run_cmd(2'd2, 3'd2, "R8 malformed first");
        lat = 2;
        load(2, 3, 32'hE300, 2, 5'b01000);
        run_cmd(2'd2, 3'd3, "R8 small order");

        // R9 equation mismatch
        load(2, 8, 32'hE400, 7, 5'b10000);
        run_cmd(2'd2, 3'd6, "R9");

        // R10 framing during verify hash
        lat = 1;
        load(2, 4, 32'hE500, 3, 5'b00001);
        run_cmd(2'd2, 3'd4, "R10 verify");

        // R6 clear
        run_cmd(2'd3, 3'd0, "R6");
        chk(key_valid == 1'b0, "R6 key_valid", 64'(key_valid), 64'd0);
        chk({work_a, work_prefix, work_pub} == '0, "R6 zeroed", 64'(work_a | work_prefix | work_pub), 64'd0);

        // R5 cached sign with no key
        run_cmd(2'd1, 3'd5, "R5");
        chk(key_valid == 1'b0, "R5 key stays invalid", 64'(key_valid), 64'd0);

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule